// File: doc/BRIEF.md
# EPP Data Cycle Engine with Sticky Timeout Flag

This block runs one enhanced-parallel-port data cycle each time the host reads or writes the port's data-cycle address. It pulls the data strobe low toward the peripheral and waits for the peripheral to raise its wait handshake. On a write it drives the byte, and on a read it captures the byte. It then releases the strobe and waits for the handshake to drop. The host access is held off with a ready signal until the cycle ends.

If the peripheral does not finish within a fixed window, the engine abandons the cycle. It then latches a sticky timeout bit in the status view and can raise an interrupt. A timed-out read returns all ones. While the bit is set, new data cycles are refused and complete at once. A build parameter picks how the bit clears: either a status read clears it, or writing a one to it clears it. When the port is not in EPP mode, the bit always reads as one.

The host sees three addresses. Status is at offset 1, control at offset 2, and the data-cycle address at offset 4.

Top module: `epp_cycle_engine`

## Requirements
- R1: After reset, control reads 0x00, the data strobe is high (inactive), irq is low, pd_oe is 1, and status reads 0x00 in EPP mode and 0x01 outside it.
- R2: Offset 2 (haddr=2) is a read/write control register that reads back the last value written. Status sits at offset 1. Offsets other than 1, 2 and 4 read 0x00 and complete without wait.
- R3: A write at offset 4 in EPP mode takes dstb_n low with hwdata on pd_out and pd_oe=1. Once pwait is seen high, the strobe is released. The access completes (hready=1) only after pwait is seen low again, and the strobe is never low while hready is high.
- R4: A read at offset 4 runs the same handshake with pd_oe=0 while the strobe is low. It returns the pd_in byte present when pwait was seen high.
- R5: If pwait does not go high, the strobe stays low for exactly TMO_CYC = CLK_MHZ*LIMIT_US clock cycles. The cycle then ends, status bit 0 becomes 1, and a read returns 0xFF.
- R6: Outside EPP mode (epp_mode=0), status bit 0 reads 1 whatever the stored flag holds.
- R7: With CLR_ON_READ=0, writing status with bit 0 set clears the flag. Writing status with bit 0 clear, or reading status, leaves it set.
- R8: With CLR_ON_READ=1, a status read returns bit 0 = 1 and then clears the flag. A status write has no effect on it.
- R9: Control bit 5 set (input direction) forces pd_oe to 0.
- R10: irq is high exactly when the timeout flag is set and control bit 4 (interrupt enable) is 1.
- R11: An access at offset 4 while the flag is set, or outside EPP mode, completes in its first cycle with no strobe. Reads return 0xFF, and writes are dropped.
- R12: If pwait stays high after the strobe is released, the cycle also times out within the same window. It sets the flag, and a read returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| epp_mode | input | 1 | Port currently in EPP mode |
| hreq | input | 1 | Host access valid, held until hready |
| hwr | input | 1 | 1 = write, 0 = read |
| haddr | input | AW | Register offset |
| hwdata | input | DW | Host write data |
| hrdata | output | DW | Host read data, valid with hready |
| hready | output | 1 | Access completes on this clock edge |
| dstb_n | output | 1 | Data strobe to the peripheral, active low |
| pwait | input | 1 | Peripheral handshake, high = responded |
| pd_out | output | DW | Data driven to the peripheral |
| pd_oe | output | 1 | Output enable for pd_out |
| pd_in | input | DW | Data from the peripheral |
| irq | output | 1 | Timeout interrupt request |

## Verification
A sequencer stuck outside its idle state shows at the ports as hready staying low, or as a strobe held longer than the timeout window, within TMO_CYC cycles. A flag that sets or clears wrongly shows on the next status read. It also shows on irq as soon as the enable bit is set, and it turns the next data cycle into an instant refusal or an unexpected strobe. A wrong capture or drive register shows as a bad byte on pd_out during the strobe, or in hrdata on the access that completes.

// File: rtl/epp_eng_pkg.sv
// Shared definitions for the EPP data cycle engine.
// Assumes a 3-bit register offset space and an 8-bit data path.
package epp_eng_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_STROBE  = 2'd1,
        S_RELEASE = 2'd2,
        S_DONE    = 2'd3
    } seq_state_t;

    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_CTRL = 3'd2;
    localparam logic [2:0] OFS_DATA = 3'd4;

    localparam int unsigned DIR_BIT = 5;
    localparam int unsigned IEN_BIT = 4;
endpackage

// File: rtl/epp_eng_regs.sv
// Control register and sticky timeout flag.
// Assumes set and clear requests are single-cycle pulses. A set wins if both occur.
module epp_eng_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [DW-1:0] ctrl_wdata,
    input  logic          flag_set,
    input  logic          flag_clr,
    output logic [DW-1:0] ctrl_q,
    output logic          flag_q
);
    // Control register: written by the host only.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    // Timeout flag: set by the sequencer, cleared by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (flag_set) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end
endmodule

// File: rtl/epp_eng_seq.sv
// Sequencer for one EPP data cycle: strobe, wait-high, release, wait-low.
// Assumes start arrives only while idle. One counter covers the whole cycle,
// and the timeout fires when it reaches LIMIT-1 before the cycle ends.
module epp_eng_seq
    import epp_eng_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LIMIT = 500,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_wr,
    input  logic [DW-1:0] wdata,
    input  logic          pwait,
    input  logic [DW-1:0] pd_in,
    output logic          idle,
    output logic          done,
    output logic          rd_active,
    output logic          dstb_n,
    output logic          tmo_hit,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);
    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic          wr_q;
    logic          expired;

    assign expired   = (cnt >= CW'(LIMIT - 1));
    assign tmo_hit   = expired && (((state == S_STROBE) && !pwait) ||
                                   ((state == S_RELEASE) && pwait));
    assign idle      = (state == S_IDLE);
    assign done      = (state == S_DONE);
    assign dstb_n    = (state != S_STROBE);
    assign rd_active = !wr_q && (state == S_STROBE || state == S_RELEASE);

    // State, window counter and data registers for the running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '1;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    state   <= S_STROBE;
                    cnt     <= '0;
                    wr_q    <= start_wr;
                    wdata_q <= wdata;
                end
                S_STROBE: begin
                    if (pwait) begin
                        if (!wr_q) rdata_q <= pd_in;
                        state <= S_RELEASE;
                        cnt   <= cnt + CW'(1);
                    end else if (expired) begin
                        rdata_q <= '1;
                        state   <= S_DONE;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                S_RELEASE: begin
                    if (!pwait) begin
                        state <= S_DONE;
                    end else if (expired) begin
                        rdata_q <= '1;
                        state   <= S_DONE;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/epp_cycle_engine.sv
// Top of the EPP data cycle engine. Decodes host offsets, starts data cycles,
// refuses them while the flag is set or outside EPP mode, and muxes read data.
// Assumes the host holds hreq and its fields stable until hready.
module epp_cycle_engine
    import epp_eng_pkg::*;
#(
    parameter int AW          = 3,
    parameter int DW          = 8,
    parameter int CLK_MHZ     = 50,
    parameter int LIMIT_US    = 10,
    parameter bit CLR_ON_READ = 1'b0,
    localparam int TMO_CYC    = CLK_MHZ * LIMIT_US
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          epp_mode,
    input  logic          hreq,
    input  logic          hwr,
    input  logic [AW-1:0] haddr,
    input  logic [DW-1:0] hwdata,
    output logic [DW-1:0] hrdata,
    output logic          hready,
    output logic          dstb_n,
    input  logic          pwait,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    input  logic [DW-1:0] pd_in,
    output logic          irq
);
    logic          hit_stat, hit_ctrl, hit_data;
    logic          start, commit;
    logic          seq_idle, seq_done, rd_active, tmo_hit;
    logic          tmo_flag, flag_clr;
    logic [DW-1:0] ctrl_q, rdata_q;

    assign hit_stat = (haddr == AW'(OFS_STAT));
    assign hit_ctrl = (haddr == AW'(OFS_CTRL));
    assign hit_data = (haddr == AW'(OFS_DATA));

    assign start  = seq_idle && hreq && hit_data && epp_mode && !tmo_flag;
    assign hready = seq_idle ? !start : seq_done;
    assign commit = seq_idle && hreq && !start;

    // Clearing semantics chosen at build time.
    generate
        if (CLR_ON_READ) begin : g_clr_rd
            assign flag_clr = commit && !hwr && hit_stat;
        end else begin : g_clr_w1
            assign flag_clr = commit && hwr && hit_stat && hwdata[0];
        end
    endgenerate

    epp_eng_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (commit && hwr && hit_ctrl),
        .ctrl_wdata (hwdata),
        .flag_set   (tmo_hit),
        .flag_clr   (flag_clr),
        .ctrl_q     (ctrl_q),
        .flag_q     (tmo_flag)
    );

    epp_eng_seq #(.DW(DW), .LIMIT(TMO_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_wr  (hwr),
        .wdata     (hwdata),
        .pwait     (pwait),
        .pd_in     (pd_in),
        .idle      (seq_idle),
        .done      (seq_done),
        .rd_active (rd_active),
        .dstb_n    (dstb_n),
        .tmo_hit   (tmo_hit),
        .wdata_q   (pd_out),
        .rdata_q   (rdata_q)
    );

    // Read data mux: finished cycle, status, control, refused cycle, unmapped.
    always_comb begin
        if (seq_done)      hrdata = rdata_q;
        else if (hit_stat) hrdata = {{(DW-1){1'b0}}, tmo_flag || !epp_mode};
        else if (hit_ctrl) hrdata = ctrl_q;
        else if (hit_data) hrdata = '1;
        else               hrdata = '0;
    end

    assign pd_oe = !ctrl_q[DIR_BIT] && !rd_active;
    assign irq   = tmo_flag && ctrl_q[IEN_BIT];
endmodule

// File: rtl/epp_eng_chk.sv
// Property checker for the EPP data cycle engine, attached by bind.
// Assumes the top-level names ctrl_q, tmo_flag and seq_idle.
module epp_eng_chk #(
    parameter int AW      = 3,
    parameter int DW      = 8,
    parameter int TMO_CYC = 500
) (
    input logic          clk,
    input logic          rst_n,
    input logic          epp_mode,
    input logic          hreq,
    input logic          hwr,
    input logic [AW-1:0] haddr,
    input logic [DW-1:0] hrdata,
    input logic          hready,
    input logic          dstb_n,
    input logic          pd_oe,
    input logic          irq,
    input logic [DW-1:0] ctrl_q,
    input logic          tmo_flag,
    input logic          seq_idle
);
    logic [31:0] low_run;

    // Count consecutive low-strobe cycles to bound the window.
    always_ff @(posedge clk) begin
        if (!rst_n)       low_run <= '0;
        else if (!dstb_n) low_run <= low_run + 32'd1;
        else              low_run <= '0;
    end

    // Check the strobe never outlasts the timeout window.
    always_ff @(posedge clk) begin
        if (rst_n) p_strobe_window_r5: assert (low_run <= 32'(TMO_CYC));
    end

    p_strobe_holds_host_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dstb_n |-> !hready);

    p_dir_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[5] |-> !pd_oe);

    p_stat_non_epp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hreq && !hwr && haddr == AW'(1) && !epp_mode) |-> hrdata[0]);

    p_refuse_now_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hreq && haddr == AW'(4) && seq_idle && (!epp_mode || tmo_flag)) |-> hready);

    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[4] |-> !irq);

    p_flag_after_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> !seq_idle || $past(!seq_idle));
endmodule

bind epp_cycle_engine epp_eng_chk #(.AW(AW), .DW(DW), .TMO_CYC(TMO_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .epp_mode (epp_mode),
    .hreq     (hreq),
    .hwr      (hwr),
    .haddr    (haddr),
    .hrdata   (hrdata),
    .hready   (hready),
    .dstb_n   (dstb_n),
    .pd_oe    (pd_oe),
    .irq      (irq),
    .ctrl_q   (ctrl_q),
    .tmo_flag (tmo_flag),
    .seq_idle (seq_idle)
);

// File: tb/sim_epp_cycle_engine.sv
// Scoreboard bench: the access task queues expected read data and a monitor
// compares each completed read. A second instance covers clear-on-read.
module sim_epp_cycle_engine;
    localparam int PERIOD = 10;
    localparam int TMO    = 20;  // CLK_MHZ=2 * LIMIT_US=10

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       epp_mode = 1'b0;
    logic       hreq = 1'b0, hwr = 1'b0, en1 = 1'b0;
    logic [2:0] haddr = '0;
    logic [7:0] hwdata = '0, pd_in = '0;
    logic       pwait;
    logic [7:0] hrdata, pd_out, u1_hrdata, u1_pd_out;
    logic       hready, dstb_n, pd_oe, irq;
    logic       u1_hready, u1_dstb_n, u1_pd_oe, u1_irq;

    int tests = 0, fails = 0;
    int pmode = 0;
    int acnt = 0, rcnt = 0, run = 0, last_len = 0, nstb = 0, last_wait = 0;
    logic       prev_dstb = 1'b1, oe_in_stb = 1'b0;
    logic [7:0] seen_out = '0, last1 = '0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(PERIOD/2) clk = ~clk;

    epp_cycle_engine #(.CLK_MHZ(2), .LIMIT_US(10), .CLR_ON_READ(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .epp_mode(epp_mode), .hreq(hreq), .hwr(hwr),
        .haddr(haddr), .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
        .dstb_n(dstb_n), .pwait(pwait), .pd_out(pd_out), .pd_oe(pd_oe),
        .pd_in(pd_in), .irq(irq));

    epp_cycle_engine #(.CLK_MHZ(2), .LIMIT_US(10), .CLR_ON_READ(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .epp_mode(epp_mode), .hreq(hreq && en1), .hwr(hwr),
        .haddr(haddr), .hwdata(hwdata), .hrdata(u1_hrdata), .hready(u1_hready),
        .dstb_n(u1_dstb_n), .pwait(pwait), .pd_out(u1_pd_out), .pd_oe(u1_pd_oe),
        .pd_in(pd_in), .irq(u1_irq));

    // Peripheral model: 0 absent, 1 normal handshake, 2 wait stuck high.
    always @(posedge clk) begin
        if (!rst_n) begin
            pwait <= 1'b0; acnt <= 0; rcnt <= 0;
        end else if (pmode == 1) begin
            if (!dstb_n && !pwait) begin
                if (acnt == 2) begin pwait <= 1'b1; acnt <= 0; end
                else acnt <= acnt + 1;
            end else if (dstb_n && pwait) begin
                if (rcnt == 1) begin pwait <= 1'b0; rcnt <= 0; end
                else rcnt <= rcnt + 1;
            end
        end else if (pmode == 2) begin
            if (!dstb_n) pwait <= 1'b1;
        end else begin
            pwait <= 1'b0;
        end
    end

    // Strobe observer: run length, count of strobes, data and enable seen.
    always @(posedge clk) begin
        prev_dstb <= dstb_n;
        if (prev_dstb && !dstb_n) nstb <= nstb + 1;
        if (!dstb_n) begin
            run <= run + 1;
            if (pd_oe) seen_out <= pd_out;
            oe_in_stb <= oe_in_stb | pd_oe;
        end else if (run != 0) begin
            last_len <= run; run <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each completed read with the queue head.
    always @(negedge clk) begin
        if (rst_n && hreq && hready && !hwr) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard empty", int'(hrdata), 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(hrdata == e, t, int'(hrdata), int'(e));
            end
        end
    end

    task automatic acc(input logic wr, input logic [2:0] a, input logic [7:0] d,
                       input logic [7:0] exp, input string tag);
        int n = 0;
        @(posedge clk); #1;
        hreq = 1'b1; hwr = wr; haddr = a; hwdata = d;
        if (!wr) begin exp_q.push_back(exp); tag_q.push_back(tag); end
        forever begin
            @(negedge clk);
            if (hready) break;
            n++;
            if (n > 1000) break;
        end
        last1 = u1_hrdata;
        last_wait = n;
        @(posedge clk); #1;
        hreq = 1'b0;
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++; tests++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int s0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dstb_n == 1'b1, "R1 strobe idle", int'(dstb_n), 1);
        chk(irq == 1'b0, "R1 irq low", int'(irq), 0);
        chk(pd_oe == 1'b1, "R1 drivers on", int'(pd_oe), 1);
        acc(1'b0, 3'd2, 8'h00, 8'h00, "R1 control reset");
        acc(1'b0, 3'd1, 8'h00, 8'h01, "R1 R6 status outside EPP");
        epp_mode = 1'b1;
        acc(1'b0, 3'd1, 8'h00, 8'h00, "R1 status in EPP");

        // R2 register map
        acc(1'b1, 3'd2, 8'h10, 8'h00, "");
        acc(1'b0, 3'd2, 8'h00, 8'h10, "R2 control readback");
        acc(1'b0, 3'd3, 8'h00, 8'h00, "R2 unmapped 3");
        chk(last_wait == 0, "R2 unmapped no wait", last_wait, 0);
        acc(1'b0, 3'd0, 8'h00, 8'h00, "R2 unmapped 0");

        // R3 write cycle
        pmode = 1;
        acc(1'b1, 3'd4, 8'hA5, 8'h00, "");
        chk(seen_out == 8'hA5, "R3 data on pins", int'(seen_out), 8'hA5);
        chk(last_wait > 3 && last_len < TMO, "R3 handshake held host", last_wait, 4);
        chk(pwait == 1'b0, "R3 completes after wait low", int'(pwait), 0);
        acc(1'b0, 3'd1, 8'h00, 8'h00, "R3 no timeout flag");

        // R4 read cycle
        pd_in = 8'h3C; oe_in_stb = 1'b0;
        acc(1'b0, 3'd4, 8'h00, 8'h3C, "R4 read data");
        chk(oe_in_stb == 1'b0, "R4 drivers off in read", int'(oe_in_stb), 0);

        // R9 direction bit
        acc(1'b1, 3'd2, 8'h20, 8'h00, "");
        @(negedge clk);
        chk(pd_oe == 1'b0, "R9 direction input", int'(pd_oe), 0);
        acc(1'b1, 3'd2, 8'h10, 8'h00, "");

        // R5 timeout with no peripheral, R10 irq enabled
        pmode = 0;
        acc(1'b0, 3'd4, 8'h00, 8'hFF, "R5 timed-out read");
        chk(last_len == TMO, "R5 strobe length", last_len, TMO);
        acc(1'b0, 3'd1, 8'h00, 8'h01, "R5 flag set");
        @(negedge clk);
        chk(irq == 1'b1, "R10 irq raised", int'(irq), 1);

        // R11 refusals while flag set
        s0 = nstb;
        acc(1'b1, 3'd4, 8'h77, 8'h00, "");
        chk(last_wait == 0, "R11 refused write immediate", last_wait, 0);
        acc(1'b0, 3'd4, 8'h00, 8'hFF, "R11 refused read");
        chk(last_wait == 0 && nstb == s0, "R11 no strobe", nstb - s0, 0);

        // R7 write-one-to-clear
        acc(1'b1, 3'd1, 8'h00, 8'h00, "");
        acc(1'b0, 3'd1, 8'h00, 8'h01, "R7 zero write keeps flag");
        acc(1'b0, 3'd1, 8'h00, 8'h01, "R7 read keeps flag");
        acc(1'b1, 3'd1, 8'h01, 8'h00, "");
        acc(1'b0, 3'd1, 8'h00, 8'h00, "R7 one write clears");
        @(negedge clk);
        chk(irq == 1'b0, "R10 irq drops", int'(irq), 0);

        // R11 and R6 outside EPP mode
        epp_mode = 1'b0; s0 = nstb;
        acc(1'b0, 3'd4, 8'h00, 8'hFF, "R11 non-EPP read");
        chk(last_wait == 0 && nstb == s0, "R11 non-EPP no strobe", nstb - s0, 0);
        acc(1'b0, 3'd1, 8'h00, 8'h01, "R6 reads one");
        epp_mode = 1'b1;

        // R12 wait stuck high after release
        pmode = 2;
        acc(1'b0, 3'd4, 8'h00, 8'hFF, "R12 stuck wait read");
        acc(1'b0, 3'd1, 8'h00, 8'h01, "R12 flag set");
        pmode = 0;
        @(negedge clk); @(negedge clk);
        acc(1'b1, 3'd1, 8'h01, 8'h00, "");

        // R10 masked interrupt
        acc(1'b1, 3'd2, 8'h00, 8'h00, "");
        acc(1'b0, 3'd4, 8'h00, 8'hFF, "R10 timeout while masked");
        @(negedge clk);
        chk(irq == 1'b0, "R10 masked", int'(irq), 0);
        acc(1'b1, 3'd1, 8'h01, 8'h00, "");

        // R8 clear-on-read instance
        en1 = 1'b1;
        acc(1'b0, 3'd4, 8'h00, 8'hFF, "R8 timeout both");
        chk(last1 == 8'hFF, "R8 u1 timed-out read", int'(last1), 8'hFF);
        acc(1'b1, 3'd1, 8'h01, 8'h00, "");
        acc(1'b0, 3'd1, 8'h00, 8'h00, "R7 u0 cleared");
        chk(last1 == 8'h01, "R8 write ignored, read sees one", int'(last1), 1);
        acc(1'b0, 3'd1, 8'h00, 8'h00, "R8 u0 still clear");
        chk(last1 == 8'h00, "R8 read cleared", int'(last1), 0);
        en1 = 1'b0;

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule